// File: doc/BRIEF.md
# Masked Port Event and Match Detector

The detector watches a set of parallel digital input ports, 16 bits each in the default build, and raises a sticky interrupt when their contents meet a condition set by software. Each port passes through a synchronizer. The synchronized value is examined only on cycles when the chosen sampling strobe is high. The strobe comes from one of several strobe sources, picked by a select input.

The detector has two modes. In change mode it fires when any bit that is not masked differs from the value captured at the previous interrupt, on any port. In pattern mode it fires when every bit that is not masked, on every port, equals the matching bit of that port's compare word. Pattern mode fires once, when the condition becomes true, and does not fire again while the condition stays true. Each time the detector fires, it copies the synchronized value of every port into that port's capture register. The status bit then stays set until a clear pulse arrives. A constant identification word lets software recognise the block.

Top module: `port_watch`

## Requirements
- R1: A port change reaches the detector after the synchronizer stages (two by default). A strobe is taken only from the source chosen by `samp_sel_i`. No firing, capture or condition update happens on a cycle when that strobe is low.
- R2: With `mode_i` = 1 (change mode), a sampled cycle fires when any unmasked bit of any port's synchronized value differs from that port's capture register.
- R3: With `mode_i` = 2 (pattern mode), the condition holds when every unmasked bit of every port equals the matching bit of that port's compare word.
- R4: Pattern mode fires only on a sampled cycle where the condition holds and it did not hold on the previous sampled cycle in this mode. Entering pattern mode counts as "did not hold".
- R5: A mask bit of 1 excludes that bit from both conditions. A mask bit of 0 includes it.
- R6: When the detector fires, each port's capture register takes that port's synchronized value at the same clock edge. The capture registers change at no other time.
- R7: The status output `irq_o` goes to 1 on the edge after firing and holds until a `clr_i` pulse clears it. If firing and clearing happen in the same cycle, firing wins.
- R8: With `mode_i` = 0 or 3 the detector never fires, and the capture registers and status stay unchanged.
- R9: `id_o` always reads 16'h0001.
- R10: After reset, `irq_o` is 0 and all capture registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_i | input | NP x W | Monitored port inputs, asynchronous |
| samp_src_i | input | NSRC | Candidate sampling strobes, synchronous |
| samp_sel_i | input | SEL_W | Index of the strobe in use |
| mode_i | input | 2 | 0 off, 1 change, 2 pattern, 3 off |
| mask_i | input | NP x W | Per-port mask, 1 = ignore bit |
| cmp_i | input | NP x W | Per-port compare words |
| clr_i | input | 1 | Pulse that clears the status bit |
| capt_o | output | NP x W | Per-port capture registers |
| id_o | output | 16 | Constant identification word |
| irq_o | output | 1 | Sticky status / interrupt |

## Verification
The bench uses the default parameters: two ports of 16 bits, four strobe sources and two synchronizer stages. With this build a mismatch on the upper port or in a high bit position shows up in both conditions. Strobe sources that are not selected can also be toggled to show that they are ignored. Directed phases cover the synchronizer latency, masking, the single-fire behaviour of pattern mode, the disabled modes and a clear pulse that meets a new firing. A long random phase then compares a behavioural model with the outputs on every clock.

// File: rtl/port_watch_pkg.sv
package port_watch_pkg;
  typedef enum logic [1:0] {
    MD_OFF   = 2'd0,
    MD_CHG   = 2'd1,
    MD_PAT   = 2'd2,
    MD_SPARE = 2'd3
  } pw_mode_e;

  localparam logic [15:0] PW_IDENT = 16'h0001;
endpackage

// File: rtl/pw_sync.sv
module pw_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain[0] <= '0;
        else         chain[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain[s] <= '0;
        else         chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pw_lane.sv
module pw_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] capt_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] cmp_i,
  output logic         chg_o,
  output logic         pat_o
);
  function automatic logic any_change(input logic [W-1:0] now,
                                      input logic [W-1:0] last,
                                      input logic [W-1:0] ign);
    return |((now ^ last) & ~ign);
  endfunction

  function automatic logic pattern_ok(input logic [W-1:0] now,
                                      input logic [W-1:0] ref_w,
                                      input logic [W-1:0] ign);
    return ((now ^ ref_w) & ~ign) == '0;
  endfunction

  assign chg_o = any_change(smp_i, capt_i, mask_i);
  assign pat_o = pattern_ok(smp_i, cmp_i, mask_i);
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import port_watch_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     strobe_i,
  input  pw_mode_e mode_i,
  input  logic     chg_any_i,
  input  logic     pat_all_i,
  input  logic     clr_i,
  output logic     fire_o,
  output logic     irq_o
);
  logic pat_prev;
  logic stat_q;

  always_comb begin
    fire_o = 1'b0;
    if (strobe_i) begin
      unique case (mode_i)
        MD_CHG:  fire_o = chg_any_i;
        MD_PAT:  fire_o = pat_all_i && !pat_prev;
        default: fire_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pat_prev <= 1'b0;
    else if (mode_i != MD_PAT)  pat_prev <= 1'b0;
    else if (strobe_i)          pat_prev <= pat_all_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_q <= 1'b0;
    else if (fire_o) stat_q <= 1'b1;
    else if (clr_i)  stat_q <= 1'b0;
  end

  assign irq_o = stat_q;
endmodule

// File: rtl/port_watch.sv
module port_watch
  import port_watch_pkg::*;
#(
  parameter int NP     = 2,
  parameter int W      = 16,
  parameter int NSRC   = 4,
  parameter int STAGES = 2,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NP-1:0][W-1:0] port_i,
  input  logic [NSRC-1:0]      samp_src_i,
  input  logic [SEL_W-1:0]     samp_sel_i,
  input  logic [1:0]           mode_i,
  input  logic [NP-1:0][W-1:0] mask_i,
  input  logic [NP-1:0][W-1:0] cmp_i,
  input  logic                 clr_i,
  output logic [NP-1:0][W-1:0] capt_o,
  output logic [15:0]          id_o,
  output logic                 irq_o
);
  logic [NP-1:0][W-1:0] smp;
  logic [NP-1:0][W-1:0] capt_q;
  logic [NP-1:0]        chg_vec;
  logic [NP-1:0]        pat_vec;
  logic                 chg_any;
  logic                 pat_all;
  logic                 strobe;
  logic                 fire;
  pw_mode_e             mode;

  assign mode    = pw_mode_e'(mode_i);
  assign strobe  = samp_src_i[samp_sel_i];
  assign chg_any = |chg_vec;
  assign pat_all = &pat_vec;

  for (genvar p = 0; p < NP; p++) begin : g_port
    pw_sync #(.W(W), .STAGES(STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (port_i[p]),
      .q_o    (smp[p])
    );

    pw_lane #(.W(W)) u_lane (
      .smp_i  (smp[p]),
      .capt_i (capt_q[p]),
      .mask_i (mask_i[p]),
      .cmp_i  (cmp_i[p]),
      .chg_o  (chg_vec[p]),
      .pat_o  (pat_vec[p])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   capt_q[p] <= '0;
      else if (fire) capt_q[p] <= smp[p];
    end
  end

  pw_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe),
    .mode_i    (mode),
    .chg_any_i (chg_any),
    .pat_all_i (pat_all),
    .clr_i     (clr_i),
    .fire_o    (fire),
    .irq_o     (irq_o)
  );

  assign capt_o = capt_q;
  assign id_o   = PW_IDENT;
endmodule

// File: rtl/port_watch_chk.sv
module port_watch_chk #(
  parameter int NP = 2,
  parameter int W  = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 fire,
  input logic                 strobe,
  input logic [1:0]           mode_i,
  input logic                 clr_i,
  input logic                 irq_o,
  input logic [NP-1:0][W-1:0] capt_o
);
  // R6
  capt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(capt_o));

  // R7
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> irq_o);

  // R7
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);

  // R7
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !fire) |=> !irq_o);

  // R1
  strobe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> strobe);

  // R8
  off_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 || mode_i == 2'd3) |-> !fire);

  // R4
  pat_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && mode_i == 2'd2) |=> !(fire && mode_i == 2'd2));
endmodule

bind port_watch port_watch_chk #(.NP(NP), .W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .fire   (fire),
  .strobe (strobe),
  .mode_i (mode_i),
  .clr_i  (clr_i),
  .irq_o  (irq_o),
  .capt_o (capt_o)
);

// File: tb/port_watch_tb.sv
`timescale 1ns/1ps
module port_watch_tb;
  localparam int NP = 2;
  localparam int W  = 16;
  localparam int NSRC = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NP-1:0][W-1:0] port = '0;
  logic [NSRC-1:0]      src = '0;
  logic [1:0]           sel = 2'd2;
  logic [1:0]           mode = 2'd0;
  logic [NP-1:0][W-1:0] mask = '0;
  logic [NP-1:0][W-1:0] cmp = '0;
  logic                 clr = 1'b0;
  logic [NP-1:0][W-1:0] capt;
  logic [15:0]          id;
  logic                 irq;

  int checks = 0;
  int errors = 0;
  string phase = "R10";

  always #2.5 clk = ~clk;

  port_watch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .port_i(port), .samp_src_i(src),
    .samp_sel_i(sel), .mode_i(mode), .mask_i(mask), .cmp_i(cmp),
    .clr_i(clr), .capt_o(capt), .id_o(id), .irq_o(irq)
  );

  // behavioural reference
  logic [W-1:0] m_s1 [NP];
  logic [W-1:0] m_s2 [NP];
  logic [W-1:0] m_capt [NP];
  bit m_stat, m_prev;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit fire, ok, stb;
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_s1[p] = '0; m_s2[p] = '0; m_capt[p] = '0; end
      m_stat = 0; m_prev = 0;
    end else begin
      stb = src[sel];
      fire = 0;
      ok = 1;
      for (int p = 0; p < NP; p++)
        for (int b = 0; b < W; b++)
          if (mask[p][b] == 1'b0 && m_s2[p][b] != cmp[p][b]) ok = 0;
      if (stb && mode == 2'd1) begin
        for (int p = 0; p < NP; p++)
          for (int b = 0; b < W; b++)
            if (mask[p][b] == 1'b0 && m_s2[p][b] != m_capt[p][b]) fire = 1;
      end
      if (stb && mode == 2'd2) fire = ok && !m_prev;
      if (mode != 2'd2) m_prev = 0;
      else if (stb) m_prev = ok;
      if (fire) for (int p = 0; p < NP; p++) m_capt[p] = m_s2[p];
      if (fire) m_stat = 1;
      else if (clr) m_stat = 0;
      for (int p = 0; p < NP; p++) begin m_s2[p] = m_s1[p]; m_s1[p] = port[p]; end
    end
    #2;
    check({phase, " irq"}, irq, m_stat);
    for (int p = 0; p < NP; p++) check({phase, " capt"}, capt[p], m_capt[p]);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; cyc(1); clr = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    // R10 reset state
    check("R10", irq, 0);
    check("R10", capt, 0);
    // R9 identification word
    check("R9", id, 16'h0001);
    rst_n = 1'b1;
    cyc(2);

    // R8: disabled modes
    phase = "R8";
    src = 4'hF;
    mode = 2'd0; port = {16'h1234, 16'hABCD}; cyc(6);
    mode = 2'd3; port = {16'h4321, 16'h0F0F}; cyc(6);
    check("R8", irq, 0);
    check("R8", capt, 0);

    // R2 / R6: change mode
    phase = "R2";
    mode = 2'd1; cyc(2);
    check("R2", irq, 1);
    check("R6", capt, {16'h4321, 16'h0F0F});
    pulse_clr(); cyc(3);
    check("R7", irq, 0);

    // R1: strobe on an unselected source does nothing
    phase = "R1";
    src = 4'b1011;
    port[1] = 16'h8000; cyc(10);
    check("R1", irq, 0);
    src = 4'b0100; cyc(1); src = 4'b0000; cyc(1);
    check("R1", irq, 1);
    check("R1", capt[1], 16'h8000);
    pulse_clr();

    // R5: masked bits are ignored
    phase = "R5";
    src = 4'hF;
    mask[0] = 16'h00FF; port[0] = 16'h0FAA; cyc(6);
    check("R5", irq, 0);
    port[0] = 16'h1F0F; cyc(6);
    check("R5", irq, 1);
    check("R5", capt[0], 16'h1F0F);
    pulse_clr();

    // R3 / R4: pattern mode
    phase = "R3";
    mode = 2'd2; mask = '0; cmp = {16'h5A5A, 16'hC3C3};
    port = {16'h5A5A, 16'h0000}; cyc(6);
    check("R3", irq, 0);
    port[0] = 16'hC3C3; cyc(6);
    check("R3", irq, 1);
    check("R3", capt, {16'h5A5A, 16'hC3C3});
    phase = "R4";
    pulse_clr(); cyc(8);
    check("R4", irq, 0);
    port[1] = 16'h5A5B; cyc(5); port[1] = 16'h5A5A; cyc(6);
    check("R4", irq, 1);

    // R7: clear in the firing cycle leaves status set
    phase = "R7";
    pulse_clr(); mode = 2'd1; mask = '0;
    port[0] = 16'h7777; cyc(2);
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(2);
    check("R7", irq, 1);
    pulse_clr(); cyc(2);
    check("R7", irq, 0);

    // random phase against model
    phase = "R2R3R6";
    for (int i = 0; i < 3000; i++) begin
      port[$urandom_range(0, NP-1)][$urandom_range(0, W-1)] ^= 1'b1;
      if ($urandom_range(0, 15) == 0) mode = 2'($urandom_range(0, 3));
      src = 4'($urandom);
      if ($urandom_range(0, 63) == 0) sel = 2'($urandom);
      if ($urandom_range(0, 31) == 0) mask = {16'($urandom) & 16'h0FF0, 16'($urandom) & 16'hF00F};
      if ($urandom_range(0, 31) == 0) cmp = port;
      clr = ($urandom_range(0, 7) == 0);
      cyc(1);
    end
    clr = 1'b0;
    cyc(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule